// File: doc/BRIEF.md
# Ripple Magnitude Comparator Chain

This block compares two unsigned operands of a configurable width and reports whether the first is larger, smaller, or equal. It is built as a chain of small comparison stages. The chain starts at the most significant end and ends at the least significant end. Each stage takes a pair of verdict flags from the stage above it, together with its own slice of both operands, and hands a refined pair of flags to the stage below. The flags of the last stage are the result.

Each stage works in one of two ways. If the flags it receives already record a difference, it forwards them unchanged. If they record equality, it decides from its own bits. A parameter selects the stage type. One type handles one bit per stage. The other handles two bits per stage, which halves the number of stages the verdict must pass through. When the wider stages are selected and the width is odd, one single-bit stage at the bottom takes the leftover bit.

The block is purely combinational. It has no clock, no reset and no storage. Its outputs follow its inputs within the same cycle as the surrounding logic.

Top module: `mag_chain`

## Requirements
- R1: `a_gt_b` is 1 exactly when `a_in` is greater than `b_in`, with both operands read as unsigned numbers.
- R2: `a_lt_b` is 1 exactly when `a_in` is less than `b_in`, with both operands read as unsigned numbers.
- R3: When `a_in` equals `b_in`, both `a_gt_b` and `a_lt_b` are 0.
- R4: `a_gt_b` and `a_lt_b` are never 1 at the same time, either at the outputs or between any two stages.
- R5: A stage that receives a decided verdict (greater or less) forwards it unchanged, whatever its own operand bits are. At the ports, this means a difference in a higher bit decides the result even when the lower bits differ the other way.
- R6: In a two-bit stage that receives equality, the upper of its two bits decides the verdict whenever it differs between the operands. The lower bit decides only when the upper bits match.
- R7: `USE_PAIR`=1 selects two-bit stages. For an odd `WIDTH`, bit 0 is then handled by a single-bit stage. `USE_PAIR`=0 selects one single-bit stage per bit. Both settings give identical results.
- R8: The most significant stage receives "equal" (both flags 0) as its incoming verdict. As a result, equal operands produce 0/0 and not some stale or forced verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| a_gt_b | output | 1 | 1 when a_in > b_in |
| a_lt_b | output | 1 | 1 when a_in < b_in |

## Verification
Every result of this block is due in the same cycle as the operands that produce it, because no register lies between input and output. The bench drives new operands shortly after a rising edge and samples the flags at the following falling edge. By then the ripple has settled, and the next operand change is still half a period away. A six-bit chain of each stage type and a five-bit chain with two-bit stages are driven with every operand pair. Each sampled verdict is compared with an integer comparison computed in the bench. Directed pairs then target higher-bit dominance, upper-bit priority inside a stage, and the leftover bottom bit.

// File: rtl/mag_chain_pkg.sv
// Shared types for the ripple magnitude comparator.
// Assumes: the gt and lt flags are never both set on a legal link.
package mag_chain_pkg;

    // Verdict carried between stages: gt = first operand larger, lt = smaller.
    typedef struct packed {
        logic gt;
        logic lt;
    } verdict_t;

    localparam verdict_t VERDICT_EQUAL = '{gt: 1'b0, lt: 1'b0};

endpackage

// File: rtl/mag_bit_stage.sv
// One-bit comparison stage.
// Forwards a decided incoming verdict; otherwise compares its single bit pair.
// Assumes: the incoming verdict never has both flags set.
module mag_bit_stage
    import mag_chain_pkg::*;
(
    input  verdict_t up_verdict,
    input  logic     a_bit,
    input  logic     b_bit,
    output verdict_t dn_verdict
);

    logic decided;

    // Detect whether a higher stage already settled the comparison.
    always_comb begin
        decided = up_verdict.gt | up_verdict.lt;
    end

    // Forward a settled verdict, or resolve from the local bit pair.
    always_comb begin
        if (decided) begin
            dn_verdict = up_verdict;
        end else begin
            dn_verdict.gt = a_bit & ~b_bit;
            dn_verdict.lt = ~a_bit & b_bit;
        end
    end

    // Guard the stage's outgoing link and its forwarding behaviour.
    always_comb begin
        assert_no_conflict_R4: assert (!(dn_verdict.gt && dn_verdict.lt))
            else $error("bit stage produced gt and lt together");
        if (decided) begin
            assert_forward_R5: assert (dn_verdict == up_verdict)
                else $error("bit stage altered a decided verdict");
        end
    end

endmodule

// File: rtl/mag_pair_stage.sv
// Two-bit comparison stage; halves the number of links a verdict ripples through.
// Forwards a decided incoming verdict; otherwise the upper bit pair has priority,
// the lower pair decides only when the upper pair matches.
// Assumes: the incoming verdict never has both flags set.
module mag_pair_stage
    import mag_chain_pkg::*;
(
    input  verdict_t   up_verdict,
    input  logic [1:0] a_pair,
    input  logic [1:0] b_pair,
    output verdict_t   dn_verdict
);

    logic decided;
    logic hi_differs;

    // Classify the incoming verdict and the upper bit pair.
    always_comb begin
        decided    = up_verdict.gt | up_verdict.lt;
        hi_differs = a_pair[1] ^ b_pair[1];
    end

    // Forward, resolve by the upper bits, or fall back to the lower bits.
    always_comb begin
        if (decided) begin
            dn_verdict = up_verdict;
        end else if (hi_differs) begin
            dn_verdict.gt = a_pair[1];
            dn_verdict.lt = b_pair[1];
        end else begin
            dn_verdict.gt = a_pair[0] & ~b_pair[0];
            dn_verdict.lt = ~a_pair[0] & b_pair[0];
        end
    end

    // Guard the outgoing link, forwarding, and upper-bit priority.
    always_comb begin
        assert_no_conflict_R4: assert (!(dn_verdict.gt && dn_verdict.lt))
            else $error("pair stage produced gt and lt together");
        if (decided) begin
            assert_forward_R5: assert (dn_verdict == up_verdict)
                else $error("pair stage altered a decided verdict");
        end
        if (!decided && (a_pair[1] != b_pair[1])) begin
            assert_upper_wins_R6: assert (dn_verdict.gt == a_pair[1])
                else $error("pair stage ignored upper-bit priority");
        end
    end

endmodule

// File: rtl/mag_chain.sv
// Unsigned magnitude comparator built as a ripple from the top bit down.
// USE_PAIR picks two-bit stages (with a one-bit tail for odd WIDTH) or
// one-bit stages throughout. Purely combinational.
// Assumes: WIDTH >= 1.
module mag_chain
    import mag_chain_pkg::*;
#(
    parameter int WIDTH    = 6,
    parameter bit USE_PAIR = 1'b1
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             a_gt_b,
    output logic             a_lt_b
);

    localparam int PAIR_STAGES = USE_PAIR ? (WIDTH / 2) : 0;
    localparam int BIT_STAGES  = USE_PAIR ? (WIDTH % 2) : WIDTH;
    localparam int STAGES      = PAIR_STAGES + BIT_STAGES;
    localparam int BIT_TOP     = WIDTH - 1 - 2 * PAIR_STAGES;

    verdict_t link [STAGES+1];

    // The top stage starts from "equal" (R8).
    assign link[0] = VERDICT_EQUAL;

    for (genvar p = 0; p < PAIR_STAGES; p++) begin : g_pair
        localparam int HI = WIDTH - 1 - 2 * p;
        mag_pair_stage u_stage (
            .up_verdict (link[p]),
            .a_pair     (a_in[HI -: 2]),
            .b_pair     (b_in[HI -: 2]),
            .dn_verdict (link[p+1])
        );
    end

    for (genvar q = 0; q < BIT_STAGES; q++) begin : g_bit
        mag_bit_stage u_stage (
            .up_verdict (link[PAIR_STAGES+q]),
            .a_bit      (a_in[BIT_TOP-q]),
            .b_bit      (b_in[BIT_TOP-q]),
            .dn_verdict (link[PAIR_STAGES+q+1])
        );
    end

    // Take the verdict from the least significant stage.
    always_comb begin
        a_gt_b = link[STAGES].gt;
        a_lt_b = link[STAGES].lt;
    end

    // Guard the port-level verdict against the operands.
    always_comb begin
        assert_equal_clear_R3: assert (!((a_in == b_in) && (a_gt_b || a_lt_b)))
            else $error("equal operands gave a nonzero verdict");
        assert_ports_exclusive_R4: assert (!(a_gt_b && a_lt_b))
            else $error("both verdict outputs set");
    end

endmodule

// File: tb/mag_chain_test.sv
// Exhaustive and directed checks for the ripple magnitude comparator.
module mag_chain_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic [5:0] a6 = '0, b6 = '0;
    logic [4:0] a5 = '0, b5 = '0;
    logic gt_p, lt_p, gt_s, lt_s, gt_o, lt_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    mag_chain #(.WIDTH(6), .USE_PAIR(1'b1)) uut (
        .a_in(a6), .b_in(b6), .a_gt_b(gt_p), .a_lt_b(lt_p));
    mag_chain #(.WIDTH(6), .USE_PAIR(1'b0)) uut_single (
        .a_in(a6), .b_in(b6), .a_gt_b(gt_s), .a_lt_b(lt_s));
    mag_chain #(.WIDTH(5), .USE_PAIR(1'b1)) uut_odd (
        .a_in(a5), .b_in(b5), .a_gt_b(gt_o), .a_lt_b(lt_o));

    // Compare one verdict against the integer reference.
    task automatic judge(input string tag, input int a, input int b,
                         input logic gt, input logic lt);
        logic eg, el;
        string req;
        eg = (a > b);
        el = (a < b);
        req = (a > b) ? "R1" : ((a < b) ? "R2" : "R3");
        checks++;
        if (gt !== eg || lt !== el) begin
            errors++;
            $display("FAIL %s %s a=%0d b=%0d actual gt/lt=%b%b expected=%b%b",
                     req, tag, a, b, gt, lt, eg, el);
        end
        checks++;
        if (gt === 1'b1 && lt === 1'b1) begin
            errors++;
            $display("FAIL R4 %s a=%0d b=%0d actual gt/lt=11 expected not 11", tag, a, b);
        end
    endtask

    // Apply operands just after a rising edge, sample at the falling edge.
    task automatic apply(input int a, input int b, input string tag);
        @(posedge clk);
        #1;
        a6 = 6'(a); b6 = 6'(b);
        a5 = 5'(a); b5 = 5'(b);
        @(negedge clk);
        judge({tag, " pair"},   a % 64, b % 64, gt_p, lt_p);
        judge({tag, " single"}, a % 64, b % 64, gt_s, lt_s);
        judge({tag, " odd"},    a % 32, b % 32, gt_o, lt_o);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual cycles=%0d expected < 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R8/R3: operands at zero must read equal.
        @(negedge clk);
        judge("R8 initial equal pair", 0, 0, gt_p, lt_p);
        judge("R8 initial equal single", 0, 0, gt_s, lt_s);
        // R5: higher bit decides despite opposite lower bits.
        apply(6'b100000, 6'b011111, "R5 msb dominates");
        apply(6'b000100, 6'b000011, "R5 mid bit dominates");
        // R6: upper bit of a pair wins over its lower bit.
        apply(6'b000010, 6'b000001, "R6 upper beats lower");
        apply(6'b000001, 6'b000010, "R6 upper beats lower rev");
        // R7: odd width tail stage decides bit 0 alone.
        apply(5'b10101, 5'b10100, "R7 tail bit gt");
        apply(5'b10100, 5'b10101, "R7 tail bit lt");
        // R1 R2 R3 R4 R7 exhaustive over all operand pairs.
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                apply(a, b, "exhaustive");
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule